// File: doc/BRIEF.md
# Programmable Local Trigger Generator

This block produces level-1 accept (L1A) pulses locally, without an external trigger source. It runs on the bunch-crossing clock, where one clock cycle is one crossing. It keeps its own bunch counter over a 3564-crossing orbit. A 32-bit control word sets four things: the trigger mode, a rate parameter N, a burst length, and how many minimum-spacing rules are applied. The three modes are once every N+1 orbits at crossing 500, once every N+1 crossings, and pseudo-random.

Software drives the block with three single-cycle commands. The toggle command starts a burst when the generator is idle and stops it when it is running. The continuous command starts an endless run. The clear command, a general reset, stops any run. The control word is captured when a run begins.

The spacing rules are enforced by a filter that tracks the age of the four most recent pulses. A candidate pulse that would break an enabled rule is dropped, not delayed. Each pulse leaves the block as a one-cycle `l1a`. `active` is high while a run is in progress.

The sequencer has three states: `ST_IDLE`, `ST_BURST` and `ST_CONT`. Its transitions are:
- START: `ST_IDLE` to `ST_BURST` on toggle.
- CONT: `ST_IDLE` or `ST_BURST` to `ST_CONT` on the continuous command.
- STOP: `ST_BURST` or `ST_CONT` to `ST_IDLE` on toggle.
- DONE: `ST_BURST` to `ST_IDLE` when the last pulse of the burst is issued.
- CLEAR: any state to `ST_IDLE` on clear.

Top module: `local_trig_gen`

## Requirements
- R1: During and right after reset, `l1a` and `active` are 0 and `bx_count` is 0.
- R2: `bx_count` advances by one every cycle from 0 to 3563 and then wraps to 0. `orbit_start` is high exactly when `bx_count` is 0.
- R3: Mode field bits [31:30] = 2'b00 (per orbit) issues one pulse every N+1 orbits, where N is bits [15:0]. `l1a` is high in the cycle in which `bx_count` reads 500.
- R4: Mode 2'b10 (per crossing) issues one candidate pulse every N+1 cycles. The spacing rules apply to these candidates only when N < 63. For N >= 63 every candidate is issued.
- R5: Mode 2'b11 (random) issues a candidate in each cycle in which a free-running 32-bit LFSR value is below N shifted left by RAND_SHIFT. N = 0 therefore never fires. The spacing rules always apply in this mode.
- R6: Rule k (k = 1..4) allows at most k pulses in any window of 3, 25, 100 or 240 cycles respectively. The rule-select field bits [29:28] enables a set of rules:
  - 2'b00 enables rules 1-4.
  - 2'b01 enables rules 1-3.
  - 2'b10 enables rules 1-2.
  - 2'b11 enables rule 1 only.

  A blocked candidate is dropped.
- R7: A burst issues (bits [27:16]) + 1 pulses, counting issued pulses only. After the last pulse, `active` falls.
- R8: The toggle command starts a burst when idle. When running, it only stops the run; it does not start another.
- R9: The continuous command runs without end until a toggle or clear command arrives. Clear stops any run.
- R10: Mode 2'b01 is reserved. A run in this mode stays active but issues no pulses.
- R11: The control word is captured when a run starts. Later changes to `ctrl_word` have no effect on that run.
- R12: `l1a` is never high unless the generator was running in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Mode [31:30], rule select [29:28], burst length minus one [27:16], N [15:0] |
| cmd_toggle | input | 1 | Single-cycle start/stop toggle command |
| cmd_cont | input | 1 | Single-cycle continuous-run command |
| cmd_clear | input | 1 | Single-cycle general clear; stops any run |
| l1a | output | 1 | One-cycle trigger pulse |
| active | output | 1 | High while a burst or continuous run is in progress |
| bx_count | output | 12 | Bunch counter, 0 to 3563 |
| orbit_start | output | 1 | High in crossing 0 of each orbit |

## Verification
The rule-spacing assertions assume that the configuration in force while a pulse is produced is the one captured at the start of that run. The stimulus therefore changes `ctrl_word` only while the block is idle, with one exception: the test of R11 changes it during a run. The assertions also assume single-cycle commands. The bench drives each command for exactly one cycle, on the falling edge. Before each rule test, the bench idles for more than 240 cycles so that no earlier pulse is still inside any window.

// File: rtl/ltg_pkg.sv
package ltg_pkg;

    localparam int RULE_CNT      = 4;
    localparam int AGE_W         = 8;
    localparam int RULE_N_LIMIT  = 63;
    localparam int CTRL_W        = 32;
    localparam int RATE_W        = 16;
    localparam int BURST_W       = 12;

    typedef enum logic [1:0] {
        MODE_ORBIT = 2'b00,
        MODE_RSVD  = 2'b01,
        MODE_BX    = 2'b10,
        MODE_RAND  = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_CONT  = 2'd2
    } run_state_e;

    typedef struct packed {
        trig_mode_e         mode;
        logic [1:0]         rule_sel;
        logic [BURST_W-1:0] burst_m1;
        logic [RATE_W-1:0]  rate_n;
    } ctrl_word_t;

    // Sliding-window length of rule idx+1 (rule k: at most k pulses)
    function automatic int rule_window(input int idx);
        case (idx)
            0:       return 3;
            1:       return 25;
            2:       return 100;
            default: return 240;
        endcase
    endfunction

endpackage

// File: rtl/ltg_bx_timer.sv
module ltg_bx_timer #(
    parameter int BX_PER_ORBIT = 3564,
    parameter int BX_W         = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [BX_W-1:0] bx_count,
    output logic            orbit_start
);

    localparam logic [BX_W-1:0] BX_LAST = BX_W'(BX_PER_ORBIT - 1);

    logic [BX_W-1:0] bx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bx_q <= '0;
        end else if (bx_q == BX_LAST) begin
            bx_q <= '0;
        end else begin
            bx_q <= bx_q + BX_W'(1);
        end
    end

    assign bx_count    = bx_q;
    assign orbit_start = (bx_q == '0);

endmodule

// File: rtl/ltg_lfsr.sv
module ltg_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] SEED = 32'h1D87_2B41,
    parameter logic [31:0] TAPS = 32'h8020_0003
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED[W-1:0];
        end else if (sr_q[0]) begin
            sr_q <= (sr_q >> 1) ^ TAPS[W-1:0];
        end else begin
            sr_q <= sr_q >> 1;
        end
    end

    assign value = sr_q;

endmodule

// File: rtl/ltg_rule_filter.sv
module ltg_rule_filter
    import ltg_pkg::*;
#(
    parameter int RULES = RULE_CNT,
    parameter int AW    = AGE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic [1:0] rule_sel,
    output logic       rules_ok
);

    localparam logic [AW-1:0] AGE_MAX = {AW{1'b1}};

    // age_q[i]: cycles since the (i+1)-th most recent pulse, saturating
    logic [AW-1:0] age_q [RULES];
    logic [RULES-1:0] pass;

    for (genvar i = 0; i < RULES; i++) begin : g_rule
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q[i] <= AGE_MAX;
                end else if (take) begin
                    age_q[i] <= AW'(1);
                end else if (age_q[i] != AGE_MAX) begin
                    age_q[i] <= age_q[i] + AW'(1);
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q[i] <= AGE_MAX;
                end else if (take) begin
                    age_q[i] <= (age_q[i-1] == AGE_MAX) ? AGE_MAX : age_q[i-1] + AW'(1);
                end else if (age_q[i] != AGE_MAX) begin
                    age_q[i] <= age_q[i] + AW'(1);
                end
            end
        end

        // rule i+1 enabled when i + rule_sel < RULES
        always_comb begin
            if ((i + int'(rule_sel)) >= RULES) begin
                pass[i] = 1'b1;
            end else begin
                pass[i] = (age_q[i] >= AW'(rule_window(i)));
            end
        end
    end

    assign rules_ok = &pass;

endmodule

// File: rtl/ltg_cand.sv
module ltg_cand
    import ltg_pkg::*;
#(
    parameter int BX_W       = 12,
    parameter int ORBIT_SLOT = 500,
    parameter int RAND_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  trig_mode_e        mode,
    input  logic [RATE_W-1:0] rate_n,
    input  logic [BX_W-1:0]   bx_count,
    input  logic [31:0]       rnd,
    output logic              cand
);

    // compare one crossing early so the registered pulse lands on the slot
    localparam logic [BX_W-1:0] PRE_SLOT = BX_W'(ORBIT_SLOT - 1);

    logic [RATE_W-1:0] bx_gap_q;
    logic [RATE_W-1:0] orb_gap_q;
    logic [31:0]       thresh;
    logic              at_pre_slot;

    assign at_pre_slot = (bx_count == PRE_SLOT);
    assign thresh      = {{(32-RATE_W){1'b0}}, rate_n} << RAND_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bx_gap_q  <= '0;
            orb_gap_q <= '0;
        end else if (!run) begin
            bx_gap_q  <= '0;
            orb_gap_q <= '0;
        end else begin
            if (mode == MODE_BX) begin
                bx_gap_q <= (bx_gap_q == rate_n) ? '0 : bx_gap_q + RATE_W'(1);
            end
            if (mode == MODE_ORBIT && at_pre_slot) begin
                orb_gap_q <= (orb_gap_q == rate_n) ? '0 : orb_gap_q + RATE_W'(1);
            end
        end
    end

    always_comb begin
        unique case (mode)
            MODE_ORBIT: cand = run && at_pre_slot && (orb_gap_q == rate_n);
            MODE_BX:    cand = run && (bx_gap_q == rate_n);
            MODE_RAND:  cand = run && (rnd < thresh);
            MODE_RSVD:  cand = 1'b0;
        endcase
    end

endmodule

// File: rtl/local_trig_gen.sv
module local_trig_gen
    import ltg_pkg::*;
#(
    parameter int          BX_PER_ORBIT = 3564,
    parameter int          ORBIT_SLOT   = 500,
    parameter int          RAND_SHIFT   = 8,
    parameter logic [31:0] LFSR_SEED    = 32'h1D87_2B41,
    localparam int         BX_W         = $clog2(BX_PER_ORBIT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     ctrl_word,
    input  logic            cmd_toggle,
    input  logic            cmd_cont,
    input  logic            cmd_clear,
    output logic            l1a,
    output logic            active,
    output logic [BX_W-1:0] bx_count,
    output logic            orbit_start
);

    run_state_e          state_q, state_d;
    ctrl_word_t          cfg_q;
    ctrl_word_t          cfg_in;
    logic [BURST_W-1:0]  remain_q;
    logic                l1a_q;
    logic                running;
    logic                cand;
    logic                rules_ok;
    logic                rules_apply;
    logic                issue;
    logic [31:0]         rnd;
    logic                leaving_idle;

    assign cfg_in  = ctrl_word_t'(ctrl_word);
    assign running = (state_q != ST_IDLE);

    ltg_bx_timer #(.BX_PER_ORBIT(BX_PER_ORBIT), .BX_W(BX_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bx_count   (bx_count),
        .orbit_start(orbit_start)
    );

    ltg_lfsr #(.W(32), .SEED(LFSR_SEED)) i_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .value(rnd)
    );

    ltg_cand #(.BX_W(BX_W), .ORBIT_SLOT(ORBIT_SLOT), .RAND_SHIFT(RAND_SHIFT)) i_cand (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .mode    (cfg_q.mode),
        .rate_n  (cfg_q.rate_n),
        .bx_count(bx_count),
        .rnd     (rnd),
        .cand    (cand)
    );

    ltg_rule_filter #(.RULES(RULE_CNT), .AW(AGE_W)) i_rules (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (issue),
        .rule_sel(cfg_q.rule_sel),
        .rules_ok(rules_ok)
    );

    assign rules_apply = (cfg_q.mode == MODE_RAND) ||
                         ((cfg_q.mode == MODE_BX) && (cfg_q.rate_n < RATE_W'(RULE_N_LIMIT)));
    assign issue = cand && (!rules_apply || rules_ok);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_clear)       state_d = ST_IDLE;
                else if (cmd_toggle) state_d = ST_BURST;   // START
                else if (cmd_cont)   state_d = ST_CONT;    // CONT
            end
            ST_BURST: begin
                if (cmd_clear)                     state_d = ST_IDLE;  // CLEAR
                else if (cmd_toggle)               state_d = ST_IDLE;  // STOP
                else if (cmd_cont)                 state_d = ST_CONT;  // CONT
                else if (issue && remain_q == '0)  state_d = ST_IDLE;  // DONE
            end
            ST_CONT: begin
                if (cmd_clear || cmd_toggle) state_d = ST_IDLE;       // CLEAR / STOP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign leaving_idle = (state_q == ST_IDLE) && (state_d != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // configuration capture, burst counter and pulse register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            remain_q <= '0;
            l1a_q    <= 1'b0;
        end else begin
            l1a_q <= issue;
            if (leaving_idle) begin
                cfg_q    <= cfg_in;
                remain_q <= cfg_in.burst_m1;
            end else if (state_q == ST_BURST && issue && remain_q != '0) begin
                remain_q <= remain_q - BURST_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        active = (state_q != ST_IDLE);
        l1a    = l1a_q;
    end

endmodule

// File: rtl/ltg_checker.sv
module ltg_checker #(
    parameter int BX_PER_ORBIT = 3564,
    parameter int ORBIT_SLOT   = 500,
    parameter int BX_W         = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            l1a,
    input logic            active,
    input logic [BX_W-1:0] bx_count,
    input logic            rules_apply,
    input logic [1:0]      mode_q,
    input logic [1:0]      rule_sel_q
);

    localparam logic [7:0] GAP_MAX = 8'hFF;

    // distances from now back to the last and second-last pulse
    logic [7:0] gap1_q, gap2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap1_q <= GAP_MAX;
            gap2_q <= GAP_MAX;
        end else if (l1a) begin
            gap1_q <= 8'd1;
            gap2_q <= (gap1_q == GAP_MAX) ? GAP_MAX : gap1_q + 8'd1;
        end else begin
            if (gap1_q != GAP_MAX) gap1_q <= gap1_q + 8'd1;
            if (gap2_q != GAP_MAX) gap2_q <= gap2_q + 8'd1;
        end
    end

    assert_bx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_count == BX_W'(BX_PER_ORBIT - 1)) |=> (bx_count == '0));

    assert_bx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_count != BX_W'(BX_PER_ORBIT - 1)) |=> (bx_count == $past(bx_count) + BX_W'(1)));

    assert_orbit_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a && mode_q == 2'b00) |-> (bx_count == BX_W'(ORBIT_SLOT)));

    assert_rule1_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a && $past(rules_apply)) |-> (gap1_q >= 8'd3));

    assert_rule2_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l1a && $past(rules_apply) && rule_sel_q != 2'b11) |-> (gap2_q >= 8'd25));

    assert_l1a_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
        l1a |-> $past(active));

endmodule

bind local_trig_gen ltg_checker #(
    .BX_PER_ORBIT(BX_PER_ORBIT),
    .ORBIT_SLOT  (ORBIT_SLOT),
    .BX_W        (BX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .l1a        (l1a),
    .active     (active),
    .bx_count   (bx_count),
    .rules_apply(rules_apply),
    .mode_q     (cfg_q.mode),
    .rule_sel_q (cfg_q.rule_sel)
);

// File: tb/test_local_trig_gen.sv
module test_local_trig_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        cmd_toggle = 1'b0;
    logic        cmd_cont = 1'b0;
    logic        cmd_clear = 1'b0;
    logic        l1a;
    logic        active;
    logic [11:0] bx_count;
    logic        orbit_start;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    int times [256];
    int bxs   [256];
    int pcount;
    int mtimes [64];
    int mcount;

    always #5 clk = ~clk;

    local_trig_gen i_local_trig_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_word  (ctrl_word),
        .cmd_toggle (cmd_toggle),
        .cmd_cont   (cmd_cont),
        .cmd_clear  (cmd_clear),
        .l1a        (l1a),
        .active     (active),
        .bx_count   (bx_count),
        .orbit_start(orbit_start)
    );

    function automatic logic [31:0] mk(input int mode, input int rsel, input int blen, input int n);
        return {mode[1:0], rsel[1:0], blen[11:0], n[15:0]};
    endfunction

    function automatic int win(input int k);
        case (k)
            1: return 3;
            2: return 25;
            3: return 100;
            default: return 240;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_toggle();
        @(negedge clk) cmd_toggle = 1'b1;
        @(negedge clk) cmd_toggle = 1'b0;
    endtask

    task automatic do_cont();
        @(negedge clk) cmd_cont = 1'b1;
        @(negedge clk) cmd_cont = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) cmd_clear = 1'b1;
        @(negedge clk) cmd_clear = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic collect(input int ncyc);
        pcount = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (l1a) begin
                if (pcount < 256) begin
                    times[pcount] = i;
                    bxs[pcount]   = int'(bx_count);
                end
                pcount++;
            end
        end
    endtask

    // window model: may a pulse at stored index j exist under rule select rsel
    function automatic bit window_ok(input int j, input int rsel);
        for (int k = 1; k <= 4; k++) begin
            if (k <= 4 - rsel) begin
                int cnt = 0;
                for (int m = 0; m < j; m++)
                    if (times[m] > times[j] - win(k)) cnt++;
                if (cnt >= k) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    // model: a candidate every cycle, accepted when all enabled windows allow it
    task automatic build_model(input int rsel, input int horizon);
        mcount = 0;
        for (int t = 0; t < horizon && mcount < 64; t++) begin
            bit ok = 1'b1;
            for (int k = 1; k <= 4; k++) begin
                if (k <= 4 - rsel) begin
                    int cnt = 0;
                    for (int m = 0; m < mcount; m++)
                        if (mtimes[m] > t - win(k)) cnt++;
                    if (cnt >= k) ok = 1'b0;
                end
            end
            if (ok) begin
                mtimes[mcount] = t;
                mcount++;
            end
        end
    endtask

    task automatic t_reset();
        idle(3);
        chk("R1 l1a in reset", int'(l1a), 0);
        chk("R1 active in reset", int'(active), 0);
        chk("R1 bx_count in reset", int'(bx_count), 0);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 active after reset", int'(active), 0);
    endtask

    task automatic t_bx_wrap();
        while (bx_count != 12'd3563) @(negedge clk);
        chk("R2 orbit_start off at 3563", int'(orbit_start), 0);
        @(negedge clk);
        chk("R2 wrap to 0", int'(bx_count), 0);
        chk("R2 orbit_start at 0", int'(orbit_start), 1);
        @(negedge clk);
        chk("R2 step to 1", int'(bx_count), 1);
    endtask

    task automatic t_per_bx_and_latch();
        int bad = 0;
        ctrl_word = mk(2, 3, 0, 4);
        do_cont();
        ctrl_word = mk(2, 3, 0, 9);   // R11: change during run must not matter
        collect(60);
        for (int j = 1; j < pcount; j++)
            if (times[j] - times[j-1] != 5) bad++;
        chk("R4 pulse count N=4", pcount, 12);
        chk("R11 spacing kept at N+1=5", bad, 0);
        do_toggle();
        chk("R9 toggle stops continuous", int'(active), 0);
        idle(2);
        collect(30);
        chk("R8 no pulses after stop", pcount, 0);
        ctrl_word = mk(2, 0, 0, 70);
        do_cont();
        collect(300);
        bad = 0;
        for (int j = 1; j < pcount; j++)
            if (times[j] - times[j-1] != 71) bad++;
        chk("R4 spacing N+1=71", bad, 0);
        chk("R4 pulse count N=70", pcount, 4);
        do_clear();
        chk("R9 clear stops", int'(active), 0);
    endtask

    task automatic t_rules(input int rsel);
        int bad = 0;
        idle(300);
        ctrl_word = mk(2, rsel, 0, 0);
        do_cont();
        collect(700);
        do_clear();
        build_model(rsel, 700);
        for (int j = 0; j < 8; j++)
            if (j >= pcount || times[j] - times[0] != mtimes[j]) bad++;
        chk($sformatf("R6 rule select %0d pulse pattern", rsel), bad, 0);
        if (rsel == 3) chk("R6 rule1 spacing 3", times[1] - times[0], 3);
        if (rsel == 2) chk("R6 rule2 third pulse at 25", times[2] - times[0], 25);
    endtask

    task automatic t_burst();
        idle(300);
        ctrl_word = mk(2, 3, 2, 2);
        do_toggle();
        chk("R8 toggle from idle starts", int'(active), 1);
        collect(40);
        chk("R7 burst of field+1=3", pcount, 3);
        chk("R7 active falls after burst", int'(active), 0);
        ctrl_word = mk(2, 3, 0, 1);
        do_toggle();
        collect(20);
        chk("R7 zero field gives one pulse", pcount, 1);
    endtask

    task automatic t_toggle_stop();
        ctrl_word = mk(2, 3, 100, 4);
        do_toggle();
        collect(20);
        chk("R8 running before stop", int'(active), 1);
        do_toggle();
        chk("R8 toggle while running stops", int'(active), 0);
        idle(2);
        collect(30);
        chk("R8 stop does not restart", pcount, 0);
        do_toggle();
        chk("R8 toggle from idle restarts", int'(active), 1);
        do_clear();
    endtask

    task automatic t_reserved();
        ctrl_word = mk(1, 0, 0, 0);
        do_cont();
        collect(200);
        chk("R10 reserved mode no pulses", pcount, 0);
        chk("R10 reserved mode stays active", int'(active), 1);
        do_clear();
        chk("R9 clear ends run", int'(active), 0);
    endtask

    task automatic t_orbit();
        int bad = 0;
        ctrl_word = mk(0, 0, 0, 1);
        do_cont();
        collect(25000);
        do_clear();
        chk("R3 at least three orbit pulses", int'(pcount >= 3), 1);
        for (int j = 0; j < pcount && j < 256; j++)
            if (bxs[j] != 500) bad++;
        chk("R3 pulses at crossing 500", bad, 0);
        chk("R3 spacing two orbits", times[1] - times[0], 7128);
        chk("R3 second spacing", times[2] - times[1], 7128);
    endtask

    task automatic t_random();
        int bad = 0;
        idle(300);
        ctrl_word = mk(3, 0, 0, 16'hFFFF);
        do_cont();
        collect(20000);
        do_clear();
        chk("R5 random count in range", int'(pcount >= 20 && pcount <= 250), 1);
        for (int j = 0; j < pcount && j < 256; j++)
            if (!window_ok(j, 0)) bad++;
        chk("R6 random pulses obey all rules", bad, 0);
        ctrl_word = mk(3, 3, 0, 0);
        do_cont();
        collect(2000);
        do_clear();
        chk("R5 N=0 random never fires", pcount, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        t_reset();
        t_bx_wrap();
        t_per_bx_and_latch();
        t_rules(3);
        t_rules(2);
        t_rules(1);
        t_rules(0);
        t_burst();
        t_toggle_stop();
        t_reserved();
        t_orbit();
        t_random();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule